// File: doc/BRIEF.md
# Bandwidth-Quota Round-Robin Channel Arbiter

This block decides which of N DMA channels (four by default) owns a shared transfer engine. A channel asks for the engine with its request line. The arbiter grants one channel at a time. While a channel holds the grant, the engine reports each beat it moves as a byte length, and the arbiter adds these lengths to a running count. When the count reaches that channel's programmed byte quota, the arbiter takes the grant away and passes it to the next requester in round-robin order. The same edge can hand the grant to a new owner. A quota of zero means the channel has no limit.

Each channel is in one of four states: idle, active, paused or halted. A channel with external start/pause enabled stops at its quota boundary and enters the paused state. It stays paused until a start pulse arrives on its external start line. An error reported while a channel holds the grant moves that channel to the halted state. Software brings it back with the channel's continue pulse. The arbiter does not grant paused or halted channels. For each channel the block keeps three sticky interrupt flags: segment done, chain done and error. Each flag has its own enable.

The beat report is a valid-qualified input. The arbiter accepts a beat on every cycle and never applies back-pressure. The engine must report beats only for the channel shown on the grant outputs. The quota of a channel must stay constant while that channel holds the grant.

Top module: `bwq_rr_arbiter`

## Requirements
- R1: After reset no grant is given, every channel state reads idle, and all interrupt flags are clear. The state encoding is 0 idle, 1 active, 2 paused, 3 halted, and channel i uses bits [2i+1:2i] of `ch_state`.
- R2: At most one channel holds the grant. `gnt` is one-hot with bit i set for channel i and matches `gnt_id` while `gnt_valid` is high. A grant appears at the first clock edge after the request is seen with the engine free.
- R3: The search for the next owner starts at the channel after the one granted last and wraps past N-1 to 0. After reset the search starts at channel 0.
- R4: When `beat_valid` is high, the granted channel's byte count grows by `beat_len`. At the edge where the count reaches or passes a nonzero quota, the grant is released and the next eligible requester is granted at that same edge.
- R5: A quota of 0 means unlimited. Such a channel keeps the grant for as long as it requests and no error is reported.
- R6: A granted channel whose request is low loses the grant at the next edge, and another requester can be granted at that same edge.
- R7: A channel with `ext_en` set that uses up its quota becomes paused (state 2) and loses the grant. A pulse on its `ext_start` clears the pause at the next edge, and the channel becomes eligible again.
- R8: When `err` is high while a channel holds the grant, that channel becomes halted (state 3) and loses the grant. Its error flag is set if `ie_err` is set for it. A pulse on its `cont` returns it to idle at the next edge.
- R9: The arbiter does not grant a paused or halted channel, even while it requests.
- R10: `seg_done` and `chain_done` set the segment and chain flags of the granted channel only when that channel's `ie_seg` or `ie_chain` is set. Otherwise they are ignored. `irq_clr` clears all three flags of a channel. A flag set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N | Per-channel request |
| quota | input | N*QW | Byte quota per channel, channel i at [QW*i +: QW]; 0 means unlimited |
| ext_en | input | N | Enables external start/pause for each channel |
| ext_start | input | N | External start pulse; clears the paused state |
| cont | input | N | Continue pulse; clears the halted state |
| beat_valid | input | 1 | The engine moved a beat for the granted channel |
| beat_len | input | LW | Bytes in the reported beat |
| err | input | 1 | Error on the granted channel's transfer |
| seg_done | input | 1 | Granted channel completed a segment |
| chain_done | input | 1 | Granted channel completed a chain |
| ie_seg | input | N | Segment interrupt enable |
| ie_chain | input | N | Chain interrupt enable |
| ie_err | input | N | Error interrupt enable |
| irq_clr | input | N | Clears a channel's interrupt flags |
| gnt_valid | output | 1 | A channel holds the grant |
| gnt_id | output | $clog2(N) | Index of the granted channel |
| gnt | output | N | One-hot grant |
| ch_state | output | 2*N | Per-channel state |
| irq_seg | output | N | Segment-done flags |
| irq_chain | output | N | Chain-done flags |
| irq_err | output | N | Error flags |

## Verification
The assertions check the following properties on every cycle:
- the grant is one-hot;
- the owner is never a paused or halted channel;
- a dropped request gives up the grant;
- an unlimited-quota owner keeps the grant;
- the byte count stays below a nonzero quota;
- an error always halts the owner;
- a quota pause always lands;
- an enabled segment event always sets its flag.

The following behaviours are shown only by the bench's scenarios:
- the order in which grants rotate, including the wrap from the last channel to the first;
- the number of beats a quota lasts;
- resumption through the external start and continue pulses;
- disabled interrupt events being ignored;
- clearing of the interrupt flags.

// File: rtl/bwq_pkg.sv
package bwq_pkg;
  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_ACTIVE = 2'd1,
    CH_PAUSED = 2'd2,
    CH_HALTED = 2'd3
  } ch_state_e;
endpackage

// File: rtl/bwq_rr_pick.sv
module bwq_rr_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] pick
);
  // Walk from the farthest candidate to the nearest so that the nearest wins.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = N; k >= 1; k--) begin
      logic [IW-1:0] ix;
      ix = IW'((int'(last) + k) % N);
      if (mask[ix]) begin
        found = 1'b1;
        pick  = ix;
      end
    end
  end
endmodule

// File: rtl/bwq_quota_cnt.sv
module bwq_quota_cnt #(
  parameter int QW = 16,
  parameter int LW = 9,
  localparam int CW = QW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          restart,
  input  logic          beat,
  input  logic [LW-1:0] len,
  input  logic [QW-1:0] quota,
  output logic          spent
);
  logic [CW-1:0] used;
  logic [CW-1:0] sum;

  assign sum   = used + CW'(len);
  assign spent = active && beat && (quota != '0) && (sum >= CW'(quota));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            used <= '0;
    else if (restart)                      used <= '0;
    else if (beat && active && quota != '0) used <= sum;
  end

  AST_QUOTA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (active && quota != '0) |-> (used < CW'(quota))); // R4
endmodule

// File: rtl/bwq_ch_ctl.sv
module bwq_ch_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic own_hit,
  input  logic err,
  input  logic pause_hit,
  input  logic ext_start,
  input  logic cont,
  input  logic seg_done,
  input  logic chain_done,
  input  logic ie_seg,
  input  logic ie_chain,
  input  logic ie_err,
  input  logic clr,
  output logic paused,
  output logic halted,
  output logic f_seg,
  output logic f_chain,
  output logic f_err
);
  logic hit_err;
  assign hit_err = own_hit && err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused  <= 1'b0;
      halted  <= 1'b0;
      f_seg   <= 1'b0;
      f_chain <= 1'b0;
      f_err   <= 1'b0;
    end else begin
      if (hit_err)   halted <= 1'b1;
      else if (cont) halted <= 1'b0;
      if (pause_hit)      paused <= 1'b1;
      else if (ext_start) paused <= 1'b0;
      if (own_hit && seg_done && ie_seg)     f_seg <= 1'b1;
      else if (clr)                          f_seg <= 1'b0;
      if (own_hit && chain_done && ie_chain) f_chain <= 1'b1;
      else if (clr)                          f_chain <= 1'b0;
      if (hit_err && ie_err)                 f_err <= 1'b1;
      else if (clr)                          f_err <= 1'b0;
    end
  end

  AST_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_err |=> halted); // R8
  AST_PAUSE_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    pause_hit |=> paused); // R7
  AST_SEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (own_hit && seg_done && ie_seg) |=> f_seg); // R10
endmodule

// File: rtl/bwq_rr_arbiter.sv
module bwq_rr_arbiter #(
  parameter int N  = 4,
  parameter int QW = 16,
  parameter int LW = 9,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic [N*QW-1:0] quota,
  input  logic [N-1:0]    ext_en,
  input  logic [N-1:0]    ext_start,
  input  logic [N-1:0]    cont,
  input  logic            beat_valid,
  input  logic [LW-1:0]   beat_len,
  input  logic            err,
  input  logic            seg_done,
  input  logic            chain_done,
  input  logic [N-1:0]    ie_seg,
  input  logic [N-1:0]    ie_chain,
  input  logic [N-1:0]    ie_err,
  input  logic [N-1:0]    irq_clr,
  output logic            gnt_valid,
  output logic [IW-1:0]   gnt_id,
  output logic [N-1:0]    gnt,
  output logic [2*N-1:0]  ch_state,
  output logic [N-1:0]    irq_seg,
  output logic [N-1:0]    irq_chain,
  output logic [N-1:0]    irq_err
);
  import bwq_pkg::*;

  logic          own_v;
  logic [IW-1:0] own_id;
  logic [IW-1:0] last;
  logic [QW-1:0] quota_a [N];
  logic [N-1:0]  paused, halted, own_hit, block_now;
  logic [N-1:0]  elig;
  logic          spent, rel_err, rel_drop, rel_quota, pause_ev, release_g, free;
  logic          found;
  logic [IW-1:0] pick;

  assign rel_err   = own_v && err;
  assign rel_drop  = own_v && !req[own_id];
  assign rel_quota = spent;
  assign release_g = rel_err || rel_drop || rel_quota;
  assign pause_ev  = rel_quota && !rel_err && !rel_drop && ext_en[own_id];
  assign free      = !own_v || release_g;
  assign elig      = req & ~paused & ~halted & ~block_now;

  bwq_rr_pick #(.N(N), .IW(IW)) u_pick (
    .mask(elig), .last(last), .found(found), .pick(pick)
  );

  bwq_quota_cnt #(.QW(QW), .LW(LW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .active(own_v), .restart(free),
    .beat(beat_valid), .len(beat_len), .quota(quota_a[own_id]), .spent(spent)
  );

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic pause_hit;
    assign quota_a[i]   = quota[QW*i +: QW];
    assign own_hit[i]   = own_v && (own_id == IW'(i));
    assign pause_hit    = pause_ev && own_hit[i];
    assign block_now[i] = own_hit[i] && (rel_err || pause_ev);

    bwq_ch_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .own_hit(own_hit[i]), .err(err),
      .pause_hit(pause_hit), .ext_start(ext_start[i]), .cont(cont[i]),
      .seg_done(seg_done), .chain_done(chain_done), .ie_seg(ie_seg[i]),
      .ie_chain(ie_chain[i]), .ie_err(ie_err[i]), .clr(irq_clr[i]),
      .paused(paused[i]), .halted(halted[i]), .f_seg(irq_seg[i]),
      .f_chain(irq_chain[i]), .f_err(irq_err[i])
    );

    ch_state_e st;
    always_comb begin
      if (halted[i])       st = CH_HALTED;
      else if (paused[i])  st = CH_PAUSED;
      else if (own_hit[i]) st = CH_ACTIVE;
      else                 st = CH_IDLE;
    end
    assign ch_state[2*i +: 2] = st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_v  <= 1'b0;
      own_id <= '0;
      last   <= IW'(N - 1);
    end else if (free) begin
      own_v <= found;
      if (found) begin
        own_id <= pick;
        last   <= pick;
      end
    end
  end

  assign gnt_valid = own_v;
  assign gnt_id    = own_id;
  assign gnt       = own_hit;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && (gnt_valid == (gnt != '0))); // R2
  AST_SKIP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    own_v |-> !(paused[own_id] || halted[own_id])); // R9
  AST_DROP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (own_v && !req[own_id]) |=> (!own_v || own_id != $past(own_id))); // R6
  AST_ZERO_QUOTA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (own_v && quota_a[own_id] == '0 && req[own_id] && !err)
      |=> (own_v && own_id == $past(own_id))); // R5
endmodule

// File: tb/bwq_rr_arbiter_tb.sv
module bwq_rr_arbiter_tb;
  localparam int N = 4, QW = 16, LW = 9, IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0] req = '0, ext_en = '0, ext_start = '0, cont = '0;
  logic [N*QW-1:0] quota = '0;
  logic beat_valid = 1'b0, err = 1'b0, seg_done = 1'b0, chain_done = 1'b0;
  logic [LW-1:0] beat_len = '0;
  logic [N-1:0] ie_seg = '0, ie_chain = '0, ie_err = '0, irq_clr = '0;
  logic gnt_valid;
  logic [IW-1:0] gnt_id;
  logic [N-1:0] gnt, irq_seg, irq_chain, irq_err;
  logic [2*N-1:0] ch_state;

  bwq_rr_arbiter #(.N(N), .QW(QW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .quota(quota), .ext_en(ext_en),
    .ext_start(ext_start), .cont(cont), .beat_valid(beat_valid),
    .beat_len(beat_len), .err(err), .seg_done(seg_done),
    .chain_done(chain_done), .ie_seg(ie_seg), .ie_chain(ie_chain),
    .ie_err(ie_err), .irq_clr(irq_clr), .gnt_valid(gnt_valid),
    .gnt_id(gnt_id), .gnt(gnt), .ch_state(ch_state), .irq_seg(irq_seg),
    .irq_chain(irq_chain), .irq_err(irq_err)
  );

  int checks = 0, errors = 0;
  int exp_q[$];
  logic pv = 1'b0;
  logic [IW-1:0] pid = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int st(input int ch);
    return int'(ch_state[2*ch +: 2]);
  endfunction

  task automatic set_quota(input int ch, input int val);
    quota[QW*ch +: QW] = QW'(val);
  endtask

  // Monitor: each newly started grant is compared against the expected queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (gnt_valid && (!pv || gnt_id != pid)) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected grant", int'(gnt_id), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(gnt_id) == e, "R3 grant order", int'(gnt_id), e);
          chk(gnt == N'(1 << e), "R2 one-hot grant", int'(gnt), 1 << e);
        end
      end
      pv  = gnt_valid;
      pid = gnt_id;
    end
  end

  initial begin
    #(8 * 20000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) set_quota(i, 64);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!gnt_valid, "R1 no grant", int'(gnt_valid), 0);
    chk(ch_state == '0, "R1 idle states", int'(ch_state), 0);
    chk((irq_seg | irq_chain | irq_err) == '0, "R1 flags clear", int'(irq_seg | irq_chain | irq_err), 0);

    // R4 quota rotation: 64-byte quota, 32-byte beats -> two beats per grant
    beat_len = 32; beat_valid = 1'b1;
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2);
    exp_q.push_back(3); exp_q.push_back(0);
    req = 4'hF;
    repeat (3) @(negedge clk);
    chk(gnt_valid && gnt_id == 1, "R4 quota handoff", int'(gnt_id), 1);
    repeat (6) @(negedge clk);
    req = '0;
    @(negedge clk);
    chk(!gnt_valid, "R6 release on drop", int'(gnt_valid), 0);

    // R2 / R6 single requester then drop
    beat_valid = 1'b0;
    exp_q.push_back(1);
    req = 4'b0010;
    @(negedge clk);
    chk(gnt_valid && gnt_id == 1, "R2 grant next cycle", int'(gnt_id), 1);
    req = '0;
    @(negedge clk);
    chk(!gnt_valid, "R6 drop releases", int'(gnt_valid), 0);

    // R5 zero quota is unlimited
    set_quota(2, 0);
    beat_valid = 1'b1; beat_len = 255;
    exp_q.push_back(2); exp_q.push_back(0);
    req = 4'b0101;
    repeat (20) @(negedge clk);
    chk(gnt_valid && gnt_id == 2, "R5 unlimited holds", int'(gnt_id), 2);
    req = 4'b0001;
    @(negedge clk);
    chk(gnt_valid && gnt_id == 0, "R6 handoff on drop", int'(gnt_id), 0);
    req = '0; beat_valid = 1'b0;
    @(negedge clk);
    set_quota(2, 64);

    // R7 external pause at quota boundary
    ext_en = 4'b0010; beat_len = 32; beat_valid = 1'b1;
    exp_q.push_back(1); exp_q.push_back(1);
    req = 4'b0010;
    repeat (3) @(negedge clk);
    chk(st(1) == 2, "R7 paused at quota", st(1), 2);
    chk(!gnt_valid, "R7 pause releases", int'(gnt_valid), 0);
    repeat (3) @(negedge clk);
    chk(!gnt_valid && st(1) == 2, "R9 paused skipped", int'(gnt_valid), 0);
    ext_start = 4'b0010;
    @(negedge clk);
    ext_start = '0;
    chk(st(1) == 0, "R7 start clears pause", st(1), 0);
    @(negedge clk);
    chk(gnt_valid && gnt_id == 1 && st(1) == 1, "R7 regrant after start", st(1), 1);
    req = '0; ext_en = '0; beat_valid = 1'b0;
    @(negedge clk);

    // R8 error halts, continue resumes
    ie_err = 4'hF;
    exp_q.push_back(2); exp_q.push_back(2);
    req = 4'b0100;
    @(negedge clk);
    chk(gnt_valid && gnt_id == 2, "R3 next after last", int'(gnt_id), 2);
    err = 1'b1;
    @(negedge clk);
    err = 1'b0;
    chk(st(2) == 3, "R8 halted", st(2), 3);
    chk(irq_err == 4'b0100, "R8 error flag", int'(irq_err), 4);
    chk(!gnt_valid, "R8 error releases", int'(gnt_valid), 0);
    repeat (2) @(negedge clk);
    chk(!gnt_valid && st(2) == 3, "R9 halted skipped", int'(gnt_valid), 0);
    cont = 4'b0100;
    @(negedge clk);
    cont = '0;
    chk(st(2) == 0, "R8 continue clears halt", st(2), 0);
    @(negedge clk);
    chk(gnt_valid && gnt_id == 2, "R8 regrant after continue", int'(gnt_id), 2);

    // R10 interrupt enables and clear
    ie_seg = 4'b0100; ie_chain = '0;
    seg_done = 1'b1; chain_done = 1'b1;
    @(negedge clk);
    seg_done = 1'b0; chain_done = 1'b0;
    chk(irq_seg == 4'b0100, "R10 seg flag set", int'(irq_seg), 4);
    chk(irq_chain == '0, "R10 disabled chain ignored", int'(irq_chain), 0);
    irq_clr = 4'b0100;
    @(negedge clk);
    irq_clr = '0;
    chk((irq_seg | irq_err) == '0, "R10 clear flags", int'(irq_seg | irq_err), 0);

    // R3 wrap: last granted 2, requesters 0 and 1 -> channel 0
    exp_q.push_back(0);
    req = 4'b0011;
    @(negedge clk);
    chk(gnt_valid && gnt_id == 0, "R3 wrap order", int'(gnt_id), 0);
    req = '0;
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all grants seen", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule